// File: doc/BRIEF.md
# SPI Register-File Access Slave

This block is the serial front end of a peripheral's register bank. An SPI master selects the slave, shifts in one command byte and then moves any number of data bytes. The command byte carries an address, a transfer direction and a status-acknowledge request. The slave converts the serial stream into single-cycle strobes on a parallel register-file interface. Control-register writes and reads use `reg_wr` and `reg_rd`. Pushes into a FIFO port and pops from one use `fifo_push` and `fifo_pop`. The status-acknowledge request produces a pulse on `ackstat_set`. The FIFO storage and the registers themselves sit outside the block.

The SPI pins are brought into the system clock domain through a configurable synchroniser chain, and SCK edges are found by oversampling. Low addresses are FIFO ports: a burst streams every byte through the same port. Higher addresses are control registers: the address steps up after each byte and stays on the last register once it gets there. Addresses beyond the register bank are dropped without any strobe. Reads prefetch. The next byte is requested from the register file while the last bit of the current byte is still on MISO, so the byte is ready for the master's next SCK rising edge.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset, and whenever ss_n is high, all strobes (`reg_wr`, `reg_rd`, `fifo_push`, `fifo_pop`, `ackstat_set`) are low and `miso` is 0.
- R2: The command byte arrives MSB first, sampled on SCK rising edges. Bits 7:3 are the address, bit 2 is zero, bit 1 selects the direction (1 = write, 0 = read) and bit 0 requests the status-acknowledge set. At most one of `reg_wr`, `reg_rd`, `fifo_push`, `fifo_pop` is high in any cycle.
- R3: A command with an address above NUM_REGS-1 (21 to 31 by default) produces no read, write, push or pop strobe, and on a read `miso` stays 0 for every data bit.
- R4: On a write to a FIFO port (address below NUM_FIFOS, 0 to 4 by default), each complete data byte gives one `fifo_push` with that byte on `reg_wdata` and the command's address on `reg_addr`. The address never changes within the burst.
- R5: On a read from a FIFO port, `fifo_pop` pulses once when the command byte completes and once after the eighth bit of each data byte, always at the command's address. The bytes appear on MISO in pop order.
- R6: On a write to a control register (addresses NUM_FIFOS to NUM_REGS-1), each complete data byte gives one `reg_wr` at the current address. The address then advances by one, except that it holds at NUM_REGS-1 (20).
- R7: On a control-register read, `reg_rd` pulses at the command address when the command completes, and again at the next (saturating) address after each data byte. The data returned on `reg_rdata` in the strobe cycle is shifted out MSB first. Its first bit is valid before the first data SCK rising edge, and later bits change on SCK falling edges.
- R8: A command with bit 0 set gives exactly one `ackstat_set` pulse when its eighth bit is captured. This happens whatever the address or direction, and also when ss_n rises straight after the command byte.
- R9: ss_n rising ends the transfer at any bit. A partially shifted data byte produces no strobe, and a partially shifted command byte produces no strobe and no `ackstat_set`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous reset, active low |
| sck | input | 1 | SPI serial clock, idles low |
| ss_n | input | 1 | SPI slave select, active low |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| reg_addr | output | 5 | Address belonging to the current strobe |
| reg_wdata | output | 8 | Write or push data belonging to the current strobe |
| reg_rdata | input | 8 | Read or pop data, returned in the strobe cycle |
| reg_wr | output | 1 | Control-register write strobe |
| reg_rd | output | 1 | Control-register read strobe |
| fifo_push | output | 1 | FIFO-port push strobe |
| fifo_pop | output | 1 | FIFO-port pop strobe |
| ackstat_set | output | 1 | One-cycle request to set the status-acknowledge flag |

## Verification
The bench builds the block with its defaults: 21 registers, 5 FIFO ports and a two-stage synchroniser. Under these values the 5-bit address field can name eleven addresses past the end of the bank, so dropped accesses can be exercised. Bursts that start at 18 or 19 reach the saturation point at 20 within three or four bytes. The two-stage chain, the edge detector and the strobe register together put the prefetched read byte about four clocks behind an SCK edge. With the bench's six-clock SCK half period, this shows whether a byte is ready before the master samples it.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;

   localparam int BYTE_W = 8;
   localparam int ADDR_W = 5;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_CMD,
      PH_DATA
   } phase_e;

   // command byte layout: address field on top, then reserved, direction, ack request
   typedef struct packed {
      logic [ADDR_W-1:0] addr;
      logic              rsvd;
      logic              write;
      logic              ack;
   } cmd_t;

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_i,
   input  logic ss_n_i,
   input  logic mosi_i,
   output logic sck_rise,
   output logic sck_fall,
   output logic ss_act,
   output logic mosi_s
);

   localparam logic [2:0] IDLE_PINS = 3'b010;

   logic [2:0] raw;
   logic [2:0] synced;
   logic       sck_prev;

   assign raw = {sck_i, ss_n_i, mosi_i};

   generate
      if (STAGES < 0 || STAGES > 8) begin : g_bad_stages
         $error("spi_in_sync: STAGES out of range");
      end
      if (STAGES == 0) begin : g_direct
         assign synced = raw;
      end else begin : g_chain
         logic [2:0] chain [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < STAGES; k++) chain[k] <= IDLE_PINS;
            end else begin
               chain[0] <= raw;
               for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
            end
         end
         assign synced = chain[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_prev <= 1'b0;
      else        sck_prev <= synced[2];
   end

   assign ss_act   = ~synced[1];
   assign mosi_s   = synced[0];
   assign sck_rise = ss_act &  synced[2] & ~sck_prev;
   assign sck_fall = ss_act & ~synced[2] &  sck_prev;

endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine
   import spi_regs_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ss_act,
   input  logic              sck_rise,
   input  logic              sck_fall,
   input  logic              mosi_s,
   input  logic              shift_en,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_data,
   output logic              byte_done,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              miso
);

   localparam int CNT_W = $clog2(BYTE_W);

   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] rx_sh;
   logic [BYTE_W-1:0] tx_sh;

   assign rx_byte   = {rx_sh[BYTE_W-2:0], mosi_s};
   assign byte_done = sck_rise && (bit_cnt == CNT_W'(BYTE_W-1));
   assign miso      = tx_sh[BYTE_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         rx_sh   <= '0;
      end else if (!ss_act) begin
         bit_cnt <= '0;
      end else if (sck_rise) begin
         bit_cnt <= bit_cnt + 1'b1;
         rx_sh   <= rx_byte;
      end
   end

   // shift only on falls inside a byte, so the MSB loaded between bytes survives
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    tx_sh <= '0;
      else if (!ss_act)                              tx_sh <= '0;
      else if (load)                                 tx_sh <= load_data;
      else if (sck_fall && shift_en && bit_cnt != 0) tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
   end

   p_cnt_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ss_act |=> (bit_cnt == '0));

   p_idle_miso_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !ss_act |=> !miso);

endmodule

// File: rtl/spi_addr_seq.sv
module spi_addr_seq
   import spi_regs_pkg::*;
#(
   parameter int NUM_REGS  = 21,
   parameter int NUM_FIFOS = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ss_act,
   input  logic              byte_done,
   input  logic [BYTE_W-1:0] rx_byte,
   output logic              in_data,
   output logic [ADDR_W-1:0] out_addr,
   output logic [BYTE_W-1:0] wdata,
   output logic              wr_stb,
   output logic              rd_stb,
   output logic              push_stb,
   output logic              pop_stb,
   output logic              ack_stb
);

   localparam logic [ADDR_W-1:0] LAST     = ADDR_W'(NUM_REGS - 1);
   localparam logic [ADDR_W-1:0] FIFO_END = ADDR_W'(NUM_FIFOS);

   generate
      if (NUM_REGS < 1 || NUM_REGS > (1 << ADDR_W) || NUM_FIFOS > NUM_REGS) begin : g_bad_map
         $error("spi_addr_seq: register map does not fit the address field");
      end
   endgenerate

   function automatic logic addr_ok(input logic [ADDR_W-1:0] a);
      return a <= LAST;
   endfunction

   function automatic logic fifo_port(input logic [ADDR_W-1:0] a);
      return a < FIFO_END;
   endfunction

   function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] a);
      if (fifo_port(a) || a >= LAST) return a;
      return a + 1'b1;
   endfunction

   phase_e            phase;
   logic [ADDR_W-1:0] addr;
   logic [ADDR_W-1:0] nxt;
   logic              dir_wr;
   cmd_t              cmd;

   assign cmd     = cmd_t'(rx_byte);
   assign nxt     = step(addr);
   assign in_data = (phase == PH_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         addr     <= '0;
         dir_wr   <= 1'b0;
         out_addr <= '0;
         wdata    <= '0;
         wr_stb   <= 1'b0;
         rd_stb   <= 1'b0;
         push_stb <= 1'b0;
         pop_stb  <= 1'b0;
         ack_stb  <= 1'b0;
      end else begin
         wr_stb   <= 1'b0;
         rd_stb   <= 1'b0;
         push_stb <= 1'b0;
         pop_stb  <= 1'b0;
         ack_stb  <= 1'b0;
         if (!ss_act) begin
            phase <= PH_IDLE;
         end else begin
            case (phase)
               PH_IDLE: phase <= PH_CMD;
               PH_CMD: if (byte_done) begin
                  phase   <= PH_DATA;
                  addr    <= cmd.addr;
                  dir_wr  <= cmd.write;
                  ack_stb <= cmd.ack;
                  if (!cmd.write && addr_ok(cmd.addr)) begin
                     out_addr <= cmd.addr;
                     rd_stb   <= !fifo_port(cmd.addr);
                     pop_stb  <= fifo_port(cmd.addr);
                  end
               end
               PH_DATA: if (byte_done) begin
                  addr <= nxt;
                  if (dir_wr) begin
                     if (addr_ok(addr)) begin
                        out_addr <= addr;
                        wdata    <= rx_byte;
                        wr_stb   <= !fifo_port(addr);
                        push_stb <= fifo_port(addr);
                     end
                  end else if (addr_ok(nxt)) begin
                     out_addr <= nxt;
                     rd_stb   <= !fifo_port(nxt);
                     pop_stb  <= fifo_port(nxt);
                  end
               end
               default: phase <= PH_IDLE;
            endcase
         end
      end
   end

   p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_stb, rd_stb, push_stb, pop_stb}));

   p_valid_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb || rd_stb || push_stb || pop_stb) |-> (out_addr <= LAST));

   p_push_port_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (push_stb || pop_stb) |-> fifo_port(out_addr));

   p_fifo_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_data && fifo_port(addr)) |=> (!in_data || $stable(addr)));

   p_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_data && addr == LAST) |=> (!in_data || addr == LAST));

   p_ack_after_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ack_stb |-> (in_data && $past(phase) == PH_CMD));

endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
   import spi_regs_pkg::*;
#(
   parameter int NUM_REGS    = 21,
   parameter int NUM_FIFOS   = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sck,
   input  logic        ss_n,
   input  logic        mosi,
   output logic        miso,
   output logic [4:0]  reg_addr,
   output logic [7:0]  reg_wdata,
   input  logic [7:0]  reg_rdata,
   output logic        reg_wr,
   output logic        reg_rd,
   output logic        fifo_push,
   output logic        fifo_pop,
   output logic        ackstat_set
);

   generate
      if (ADDR_W != 5 || BYTE_W != 8) begin : g_bad_port
         $error("spi_reg_slave: port widths disagree with the package");
      end
   endgenerate

   logic              sck_rise;
   logic              sck_fall;
   logic              ss_act;
   logic              mosi_s;
   logic              byte_done;
   logic [BYTE_W-1:0] rx_byte;
   logic              in_data;

   spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .sck_i    (sck),
      .ss_n_i   (ss_n),
      .mosi_i   (mosi),
      .sck_rise (sck_rise),
      .sck_fall (sck_fall),
      .ss_act   (ss_act),
      .mosi_s   (mosi_s)
   );

   spi_bit_engine u_bits (
      .clk       (clk),
      .rst_n     (rst_n),
      .ss_act    (ss_act),
      .sck_rise  (sck_rise),
      .sck_fall  (sck_fall),
      .mosi_s    (mosi_s),
      .shift_en  (in_data),
      .load      (reg_rd | fifo_pop),
      .load_data (reg_rdata),
      .byte_done (byte_done),
      .rx_byte   (rx_byte),
      .miso      (miso)
   );

   spi_addr_seq #(
      .NUM_REGS  (NUM_REGS),
      .NUM_FIFOS (NUM_FIFOS)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .ss_act    (ss_act),
      .byte_done (byte_done),
      .rx_byte   (rx_byte),
      .in_data   (in_data),
      .out_addr  (reg_addr),
      .wdata     (reg_wdata),
      .wr_stb    (reg_wr),
      .rd_stb    (reg_rd),
      .push_stb  (fifo_push),
      .pop_stb   (fifo_pop),
      .ack_stb   (ackstat_set)
   );

endmodule

// File: tb/spi_reg_slave_test.sv
module spi_reg_slave_test;

   localparam int HALF  = 6;
   localparam int NREG  = 21;
   localparam int NFIFO = 5;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       sck, ss_n, mosi, miso;
   logic [4:0] reg_addr;
   logic [7:0] reg_wdata, rdata_r;
   logic       reg_wr, reg_rd, fifo_push, fifo_pop, ackstat_set;

   always #5 clk = ~clk;

   spi_reg_slave uut (
      .clk(clk), .rst_n(rst_n), .sck(sck), .ss_n(ss_n), .mosi(mosi), .miso(miso),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_r),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .fifo_push(fifo_push), .fifo_pop(fifo_pop),
      .ackstat_set(ackstat_set)
   );

   int checks = 0;
   int failures = 0;
   int cyc = 0;

   logic [7:0] regs [32];
   logic [7:0] fifo_q [NFIFO][$];
   int         exp_q[$];
   string      exp_tag[$];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int enc(input int kind, input int a, input int d);
      return (kind << 16) | (a << 8) | d;
   endfunction

   function automatic int step(input int a);
      if (a < NFIFO || a >= NREG - 1) return a;
      return a + 1;
   endfunction

   task automatic expect_ev(input int kind, input int a, input int d, input string tag);
      exp_q.push_back(enc(kind, a, d));
      exp_tag.push_back(tag);
   endtask

   task automatic seen(input int kind, input int a, input int d);
      int    e;
      string t;
      if (exp_q.size() == 0) begin
         check(1'b0, "R2 unexpected strobe", enc(kind, a, d), -1);
      end else begin
         e = exp_q.pop_front();
         t = exp_tag.pop_front();
         check(e == enc(kind, a, d), t, enc(kind, a, d), e);
      end
   endtask

   // reference register file and strobe comparison, every clock
   always @(negedge clk) begin
      if (rst_n) begin
         if (ackstat_set) seen(4, 0, 0);
         if (reg_wr) begin
            seen(0, reg_addr, reg_wdata);
            regs[reg_addr] = reg_wdata;
         end
         if (fifo_push) begin
            seen(2, reg_addr, reg_wdata);
            if (reg_addr < NFIFO) fifo_q[reg_addr].push_back(reg_wdata);
         end
         if (reg_rd) begin
            seen(1, reg_addr, 0);
            rdata_r = regs[reg_addr];
         end
         if (fifo_pop) begin
            seen(3, reg_addr, 0);
            if (reg_addr < NFIFO && fifo_q[reg_addr].size() > 0)
               rdata_r = fifo_q[reg_addr].pop_front();
            else
               rdata_r = 8'h00;
         end
      end
   end

   task automatic shift_bits(input logic [7:0] b, input int n, output logic [7:0] got);
      got = '0;
      for (int i = 0; i < n; i++) begin
         mosi = b[7-i];
         repeat (HALF) @(negedge clk);
         got = {got[6:0], miso};
         sck = 1'b1;
         repeat (HALF) @(negedge clk);
         sck = 1'b0;
      end
   endtask

   task automatic xfer(input int addr, input bit wr, input bit ack, input int nbytes,
                       input int tail_bits, input int cmd_bits, input string tag);
      logic [7:0] cmd, got, d;
      logic [7:0] wd[$];
      logic [7:0] er[$];
      logic [7:0] fc[$];
      int         a, na;
      bit         valid, fifo;
      cmd   = {addr[4:0], 1'b0, wr, ack};
      a     = addr;
      valid = addr < NREG;
      fifo  = addr < NFIFO;
      if (fifo) fc = fifo_q[addr];
      if (cmd_bits == 8) begin
         if (ack) expect_ev(4, 0, 0, "R8 ack pulse");
         if (!wr && valid) expect_ev(fifo ? 3 : 1, a, 0, tag);
         for (int i = 0; i < nbytes; i++) begin
            if (wr) begin
               d = 8'(8'h3C ^ (i * 37) + addr);
               wd.push_back(d);
               if (valid) expect_ev(fifo ? 2 : 0, a, d, tag);
               a = step(a);
            end else begin
               if (!valid)              er.push_back(8'h00);
               else if (!fifo)          er.push_back(regs[a]);
               else if (fc.size() > 0)  er.push_back(fc.pop_front());
               else                     er.push_back(8'h00);
               na = step(a);
               if (valid) expect_ev(fifo ? 3 : 1, na, 0, tag);
               a = na;
            end
         end
      end
      ss_n = 1'b0;
      repeat (3) @(negedge clk);
      shift_bits(cmd, cmd_bits, got);
      if (cmd_bits == 8) begin
         for (int i = 0; i < nbytes; i++) begin
            shift_bits(wr ? wd[i] : 8'h00, 8, got);
            if (!wr) check(got == er[i], {tag, " read byte"}, got, er[i]);
         end
         if (tail_bits > 0) shift_bits(8'hA5, tail_bits, got);
      end
      repeat (HALF) @(negedge clk);
      ss_n = 1'b1;
      repeat (12) @(negedge clk);
      check(exp_q.size() == 0, {tag, " missing strobe"}, exp_q.size(), 0);
      check(miso == 1'b0, "R1 idle miso", miso, 0);
      exp_q.delete();
      exp_tag.delete();
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         failures++;
         $display("FAIL R1 watchdog actual=%0d expected=done", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 32; i++) regs[i] = 8'(i * 7 + 1);
      for (int i = 0; i < 4; i++) fifo_q[4].push_back(8'(8'hC0 + i * 9));
      rdata_r = 8'h00;
      sck = 1'b0; ss_n = 1'b1; mosi = 1'b0; rst_n = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check({reg_wr, reg_rd, fifo_push, fifo_pop, ackstat_set, miso} == 6'b0,
            "R1 reset idle", {reg_wr, reg_rd, fifo_push, fifo_pop, ackstat_set, miso}, 0);

      xfer(6,  1, 0, 3, 0, 8, "R6 ctrl write increment");
      xfer(18, 0, 0, 4, 0, 8, "R7 ctrl read saturate");
      xfer(20, 1, 0, 3, 0, 8, "R6 write holds at last");
      xfer(19, 1, 1, 3, 0, 8, "R6 write into last");
      xfer(2,  1, 0, 3, 0, 8, "R4 fifo push");
      xfer(2,  0, 0, 2, 0, 8, "R5 fifo pop after push");
      xfer(4,  0, 0, 3, 0, 8, "R5 fifo pop stream");
      xfer(7,  0, 0, 3, 0, 8, "R7 read back written");
      xfer(18, 0, 1, 0, 0, 8, "R8 truncated ack");
      xfer(25, 1, 1, 2, 0, 8, "R3 invalid write");
      xfer(30, 0, 0, 2, 0, 8, "R3 invalid read");
      xfer(10, 1, 0, 1, 5, 8, "R9 partial data byte");
      xfer(12, 1, 1, 0, 0, 4, "R9 partial command");
      xfer(5,  1, 0, 2, 0, 8, "R2 first ctrl address");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule